// File: doc/BRIEF.md
# Hexagonal Neighbour Coincidence Trigger

This block forms a local topological trigger for a camera whose pixels lie on a hexagonal grid. Each pixel delivers a one-bit discriminator pulse. The block stretches every pulse into a programmable coincidence window. It then marks a pixel as hit when that pixel is active in the same cycle as at least two of its six grid neighbours. The result is a three-fold local coincidence, not a majority count over the whole camera.

The registered hit mask feeds two outputs. The first is a camera trigger flag. The trigger flag comes with a timestamp from a free-running cycle counter. The second is a serial stream of row and column coordinates for the hit pixels, one per clock. A later stage uses these coordinates to accumulate image moments. The grid size is set by parameters. The fabric clock is expected to run in the hundreds of MHz.

Top module: `hex_coinc_trigger`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released, hit_mask, cam_trig, trig_stamp, coord_valid, coord_row and coord_col are all zero.
- R2: A pixel input that is high at a rising edge makes that pixel active for exactly win_cfg+1 cycles, starting at that edge. A new pulse restarts the count. Pulses on neighbouring pixels coincide only when their windows overlap.
- R3: Pixel index is row*COLS+col. In even rows, the upper and lower neighbours are at columns col-1 and col. In odd rows they are at columns col and col+1. The same-row neighbours are col-1 and col+1. A neighbour position outside the grid counts as inactive.
- R4: hit_mask bit i is high one cycle after pixel i is active in a cycle where at least two of its neighbours are also active. An active pixel with fewer than two active neighbours never sets its bit.
- R5: cam_trig equals the OR of hit_mask delayed by one cycle.
- R6: A counter starts at zero on reset release and increments every cycle. It is copied into trig_stamp on the edge where cam_trig rises, and trig_stamp holds its value otherwise.
- R7: On the edge where cam_trig rises, if the coordinate scanner is empty, the current hit_mask is captured. From the next cycle onward, coord_valid is high with coord_row and coord_col of one captured pixel per clock, lowest index first, until all captured pixels have been sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| win_cfg | input | WIN_W | Coincidence window length minus one, in cycles |
| l1_in | input | ROWS*COLS | Per-pixel discriminator bits |
| hit_mask | output | ROWS*COLS | Registered per-pixel hit decision |
| cam_trig | output | 1 | Camera-level trigger flag |
| trig_stamp | output | TS_W | Cycle count captured when the trigger rises |
| coord_valid | output | 1 | A hit coordinate is presented this cycle |
| coord_row | output | max(1,clog2(ROWS)) | Row of the presented hit pixel |
| coord_col | output | max(1,clog2(COLS)) | Column of the presented hit pixel |

## Verification
On every cycle, the assertions check the following: an input pulse always arms its pixel's window, and no hit bit appears without its pixel having been active. They also check that the trigger tracks the delayed OR of the mask, that the stamp moves only when the trigger rises, and that presented coordinates always lie inside the grid. The bench scenarios are needed for the rest. Only they can show that the offset-row neighbour pattern is correct on even and odd rows and at the edges, and that the window length matches win_cfg. They also show whether staggered pulses coincide or not, and that the coordinate stream comes out in ascending order with the right count.

// File: rtl/hex_trig_pkg.sv
package hex_trig_pkg;

  localparam int NB_COUNT = 6;
  localparam int HIT_MIN  = 2;

  // Flat index of neighbour k of (r,c) on an offset-row hex grid, or -1
  // when that position falls off the grid.
  function automatic int nb_index(input int r, input int c, input int k,
                                  input int rows, input int cols);
    int  dr;
    int  dc;
    int  nr;
    int  nc;
    bit  odd;
    odd = ((r % 2) == 1);
    case (k)
      0:       begin dr = 0;  dc = -1;               end
      1:       begin dr = 0;  dc = 1;                end
      2:       begin dr = -1; dc = odd ? 0 : -1;     end
      3:       begin dr = -1; dc = odd ? 1 : 0;      end
      4:       begin dr = 1;  dc = odd ? 0 : -1;     end
      default: begin dr = 1;  dc = odd ? 1 : 0;      end
    endcase
    nr = r + dr;
    nc = c + dc;
    if (nr < 0 || nr >= rows || nc < 0 || nc >= cols) return -1;
    return nr * cols + nc;
  endfunction

endpackage

// File: rtl/pulse_stretch.sv
module pulse_stretch #(
  parameter int WIN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIN_W-1:0] win_cfg,
  input  logic             pulse,
  output logic             active
);

  localparam int CNT_W = WIN_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = pulse || (cnt_q != '0);
    if (pulse) cnt_d = {1'b0, win_cfg} + CNT_W'(1);
    else       cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);

endmodule

// File: rtl/hex_neighbour_core.sv
module hex_neighbour_core
  import hex_trig_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int NPIX = ROWS * COLS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIX-1:0] act,
  output logic [NPIX-1:0] hit_mask
);

  logic [NPIX-1:0] hit_d;

  always_comb begin
    hit_d = '0;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        int n_act;
        n_act = 0;
        for (int k = 0; k < NB_COUNT; k++) begin
          int idx;
          idx = nb_index(r, c, k, ROWS, COLS);
          if (idx >= 0) begin
            if (act[idx]) n_act = n_act + 1;
          end
        end
        hit_d[r*COLS+c] = act[r*COLS+c] && (n_act >= HIT_MIN);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_mask <= '0;
    else        hit_mask <= hit_d;
  end

endmodule

// File: rtl/hit_serializer.sv
module hit_serializer #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int NPIX  = ROWS * COLS,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NPIX-1:0]  mask,
  output logic             coord_valid,
  output logic [ROW_W-1:0] coord_row,
  output logic [COL_W-1:0] coord_col
);

  logic [NPIX-1:0]  pend_q;
  logic [NPIX-1:0]  pend_d;
  logic             vld_d;
  logic [ROW_W-1:0] row_d;
  logic [COL_W-1:0] col_d;
  int               sel;
  logic             found;

  always_comb begin
    sel   = 0;
    found = 1'b0;
    for (int i = NPIX - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        sel   = i;
        found = 1'b1;
      end
    end
    pend_d = pend_q;
    vld_d  = 1'b0;
    row_d  = '0;
    col_d  = '0;
    if (found) begin
      pend_d[sel] = 1'b0;
      vld_d       = 1'b1;
      row_d       = ROW_W'(sel / COLS);
      col_d       = COL_W'(sel % COLS);
    end else if (load) begin
      pend_d = mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= '0;
      coord_valid <= 1'b0;
      coord_row   <= '0;
      coord_col   <= '0;
    end else begin
      pend_q      <= pend_d;
      coord_valid <= vld_d;
      coord_row   <= row_d;
      coord_col   <= col_d;
    end
  end

endmodule

// File: rtl/hex_coinc_trigger.sv
module hex_coinc_trigger #(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int WIN_W = 4,
  parameter int TS_W  = 32,
  localparam int NPIX  = ROWS * COLS,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIN_W-1:0] win_cfg,
  input  logic [NPIX-1:0]  l1_in,
  output logic [NPIX-1:0]  hit_mask,
  output logic             cam_trig,
  output logic [TS_W-1:0]  trig_stamp,
  output logic             coord_valid,
  output logic [ROW_W-1:0] coord_row,
  output logic [COL_W-1:0] coord_col
);

  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic [NPIX-1:0] act;
  logic [TS_W-1:0] ts_q;
  logic            any_hit;
  logic            trig_rise;

  // Reset asserts at once, releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  for (genvar p = 0; p < NPIX; p++) begin : g_pix
    pulse_stretch #(.WIN_W(WIN_W)) u_str (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .win_cfg(win_cfg),
      .pulse  (l1_in[p]),
      .active (act[p])
    );
  end

  hex_neighbour_core #(.ROWS(ROWS), .COLS(COLS)) u_core (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .act     (act),
    .hit_mask(hit_mask)
  );

  assign any_hit   = |hit_mask;
  assign trig_rise = any_hit && !cam_trig;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ts_q       <= '0;
      cam_trig   <= 1'b0;
      trig_stamp <= '0;
    end else begin
      ts_q     <= ts_q + TS_W'(1);
      cam_trig <= any_hit;
      if (trig_rise) trig_stamp <= ts_q;
    end
  end

  hit_serializer #(.ROWS(ROWS), .COLS(COLS)) u_ser (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load       (trig_rise),
    .mask       (hit_mask),
    .coord_valid(coord_valid),
    .coord_row  (coord_row),
    .coord_col  (coord_col)
  );

endmodule

// File: rtl/hex_coinc_trigger_checker.sv
module hex_coinc_trigger_checker #(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int TS_W  = 32,
  localparam int NPIX  = ROWS * COLS,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPIX-1:0]  l1_in,
  input logic [NPIX-1:0]  act,
  input logic [NPIX-1:0]  hit_mask,
  input logic             cam_trig,
  input logic [TS_W-1:0]  trig_stamp,
  input logic             coord_valid,
  input logic [ROW_W-1:0] coord_row,
  input logic [COL_W-1:0] coord_col
);

  p_stretch_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((act & $past(l1_in)) == $past(l1_in)));

  p_hit_needs_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((hit_mask & ~$past(act)) == '0));

  p_trig_follows_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_mask) |=> cam_trig);

  p_trig_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(|hit_mask) |=> !cam_trig);

  p_stamp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(cam_trig) |-> $stable(trig_stamp));

  p_coord_in_grid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    coord_valid |-> (int'(coord_row) < ROWS && int'(coord_col) < COLS));

endmodule

bind hex_coinc_trigger hex_coinc_trigger_checker #(
  .ROWS(ROWS), .COLS(COLS), .TS_W(TS_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .l1_in      (l1_in),
  .act        (act),
  .hit_mask   (hit_mask),
  .cam_trig   (cam_trig),
  .trig_stamp (trig_stamp),
  .coord_valid(coord_valid),
  .coord_row  (coord_row),
  .coord_col  (coord_col)
);

// File: tb/hex_coinc_trigger_test.sv
`timescale 1ns/1ps
module hex_coinc_trigger_test;

  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int NPIX = ROWS * COLS;

  // {stimulus pattern, expected hit mask}; pixel index = row*4+col
  localparam logic [31:0] VEC [0:7] = '{
    32'h0013_0013,   // corner triangle 0,1,4
    32'h0003_0000,   // pair only
    32'h0026_0026,   // 1,2,5 odd-row diagonal
    32'h0121_0000,   // 0,5,8: not neighbours (parity check)
    32'h1210_0200,   // 9 with even-row diagonals 4 and 12
    32'hFFFF_FFFF,   // full camera
    32'h0020_0000,   // lone pixel
    32'hC800_C800    // far corner 11,14,15
  };

  logic             clk;
  logic             rst_n;
  logic [3:0]       win_cfg;
  logic [NPIX-1:0]  l1_in;
  logic [NPIX-1:0]  hit_mask;
  logic             cam_trig;
  logic [31:0]      trig_stamp;
  logic             coord_valid;
  logic [1:0]       coord_row;
  logic [1:0]       coord_col;

  int checks;
  int errors;
  int cyc;

  hex_coinc_trigger uut (
    .clk(clk), .rst_n(rst_n), .win_cfg(win_cfg), .l1_in(l1_in),
    .hit_mask(hit_mask), .cam_trig(cam_trig), .trig_stamp(trig_stamp),
    .coord_valid(coord_valid), .coord_row(coord_row), .coord_col(coord_col)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h at cycle %0d", req, got, exp, cyc);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] prev_stamp;
    int          prev_cyc;
    bit          have_prev;
    checks = 0; errors = 0; cyc = 0;
    have_prev = 1'b0; prev_stamp = '0; prev_cyc = 0;
    rst_n = 1'b0; win_cfg = 4'd0; l1_in = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    l1_in = 16'hFFFF;
    @(negedge clk);
    chk("R1 hit_mask", 32'(hit_mask), 0);
    chk("R1 cam_trig", 32'(cam_trig), 0);
    chk("R1 coord_valid", 32'(coord_valid), 0);
    chk("R1 trig_stamp", trig_stamp, 0);
    l1_in = '0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 outputs after release", {16'(hit_mask), 2'(coord_row), 2'(coord_col),
        1'(cam_trig), 1'(coord_valid)}, 0);
    repeat (6) @(negedge clk);

    // Vector table: R3 topology, R4 hit rule, R5 trigger, R6 stamp, R7 coordinates
    foreach (VEC[v]) begin
      logic [15:0] pat;
      logic [15:0] exp;
      pat = VEC[v][31:16];
      exp = VEC[v][15:0];
      l1_in = pat;
      @(negedge clk);
      l1_in = '0;
      @(negedge clk);
      chk($sformatf("R3/R4 vector %0d hit_mask", v), 32'(hit_mask), 32'(exp));
      @(negedge clk);
      chk($sformatf("R5 vector %0d cam_trig", v), 32'(cam_trig), 32'(exp != 0));
      if (exp != 0) begin
        if (have_prev)
          chk($sformatf("R6 vector %0d stamp delta", v), trig_stamp - prev_stamp,
              32'(cyc - prev_cyc));
        prev_stamp = trig_stamp;
        prev_cyc   = cyc;
        have_prev  = 1'b1;
      end
      for (int b = 0; b < NPIX; b++) begin
        if (exp[b]) begin
          @(negedge clk);
          chk($sformatf("R7 vector %0d coord", v),
              {31'(coord_valid), 1'b0} | {28'(coord_row), 2'(coord_col)} << 0,
              {31'(1), 1'b0} | 32'({2'(b / COLS), 2'(b % COLS)}));
        end
      end
      @(negedge clk);
      chk($sformatf("R7 vector %0d stream end", v), 32'(coord_valid), 0);
      repeat (20) @(negedge clk);
    end

    // R2: window length win_cfg+1 = 4 cycles
    win_cfg = 4'd3;
    @(negedge clk);
    l1_in = 16'h0013;
    @(negedge clk);
    l1_in = '0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk($sformatf("R2 window cycle %0d", k), 32'(hit_mask), 32'h13);
    end
    @(negedge clk);
    chk("R2 window closed", 32'(hit_mask), 0);
    repeat (24) @(negedge clk);

    // R2: staggered pulses overlap with a 4-cycle window
    l1_in = 16'h0001; @(negedge clk);
    l1_in = '0;       @(negedge clk);
    l1_in = 16'h0002; @(negedge clk);
    l1_in = 16'h0010; @(negedge clk);
    l1_in = '0;       @(negedge clk);
    chk("R2 staggered overlap", 32'(hit_mask), 32'h13);
    repeat (24) @(negedge clk);

    // R2: same stagger with a 1-cycle window never coincides
    win_cfg = 4'd0;
    @(negedge clk);
    l1_in = 16'h0001; @(negedge clk);
    l1_in = '0;       @(negedge clk);
    l1_in = 16'h0002; @(negedge clk);
    l1_in = 16'h0010; @(negedge clk);
    l1_in = '0;       @(negedge clk);
    chk("R2 no overlap", 32'(hit_mask), 0);
    @(negedge clk);
    chk("R2 no overlap trigger", 32'(cam_trig), 0);
    repeat (4) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule